// File: doc/BRIEF.md
# PCI Target Data-Phase Tracker

This block runs beside a PCI target once the target's address decoder has claimed a transaction. A one-clock claim strobe captures the starting byte address. From the next clock on, the block watches FRAME#, IRDY#, TRDY# and STOP# on each clock. It reports when a dword actually moves, when a data phase completes, when the master has entered its final phase and when the transaction ends. It also keeps the dword address of the current phase so the data path can index its buffers.

The two low bits of the starting address choose the burst ordering. Only linear increment (`00`) is carried out. For any other code the block raises its STOP# request from the first data phase onward, so the first transfer becomes a disconnect with data. The request stays up until FRAME# is sampled high. The target's own logic drives TRDY# and STOP# on the bus. This block only observes them and offers the STOP# request.

Top module: `pci_dphase_tracker`

## Requirements
- R1: While a transaction is active, `xfer_o` is high in exactly those clocks where IRDY# and TRDY# are both low. It is low at all other times.
- R2: While a transaction is active, `phase_done_o` is high in exactly those clocks where IRDY# is low and at least one of TRDY# or STOP# is low.
- R3: `eot_o` pulses in the clock where the final phase completes. That clock has FRAME# high with IRDY# and TRDY# low, or it has IRDY# and STOP# low. If FRAME# is high in that clock, the block is idle on the next clock with `stop_req_o` low.
- R4: While a transaction is in its data phases, `last_phase_o` is high whenever FRAME# is high or STOP# is low. This covers the clocks before the final phase completes.
- R5: A claim taken while idle loads `dword_addr_o` on the next clock with the starting address, its bits [1:0] forced to zero.
- R6: With starting address bits [1:0] = `00`, `dword_addr_o` grows by 4 after every clock with `xfer_o` high. It holds on wait clocks, and `stop_req_o` stays low.
- R7: With starting address bits [1:0] = `01`, `10` or `11`, `stop_req_o` is high from the first clock after the claim. The first transfer is therefore a disconnect with data.
- R8: When the final phase completes with STOP# low and FRAME# still low, `stop_req_o` stays high on later clocks while FRAME# is low. It falls on the clock after FRAME# is sampled high.
- R9: A claim during an active or stop-holding transaction has no effect on the address or the STOP# request. Handshake activity while idle produces no strobes.
- R10: After reset the block is idle, all strobes and `stop_req_o` are low, and `dword_addr_o` is zero. A reset in mid-transaction returns it to that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| claim_i | input | 1 | One-clock strobe: transaction claimed, start address valid |
| start_addr_i | input | ADDR_W | Starting byte address of the claimed transaction |
| frame_n_i | input | 1 | Observed FRAME#, active low |
| irdy_n_i | input | 1 | Observed IRDY#, active low |
| trdy_n_i | input | 1 | Observed TRDY#, active low |
| stop_n_i | input | 1 | Observed STOP#, active low |
| stop_req_o | output | 1 | Request for the target to drive STOP# low |
| xfer_o | output | 1 | Data-valid strobe: a dword moves this clock |
| phase_done_o | output | 1 | Current data phase completes this clock |
| last_phase_o | output | 1 | Current data phase is the final one |
| eot_o | output | 1 | End-of-transaction pulse |
| dword_addr_o | output | ADDR_W | Dword address of the current data phase, bits [1:0] zero |

## Verification
The linear burst is driven with target wait clocks and master wait clocks placed between transfers. This separates an address that advances on a completed transfer from one that advances on IRDY# or TRDY# alone. Each non-zero ordering code is tried with FRAME# still low at the first transfer and with FRAME# already high. This separates holding STOP# until FRAME# rises from dropping it at the end pulse. A single-dword linear transfer and a burst ended by an outside STOP# without data tell a master-signalled end apart from a target-signalled one. A claim during a burst and handshake activity while idle show that both are ignored.

// File: rtl/pci_dpt_pkg.sv
package pci_dpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_HOLD = 2'd2
    } dpt_state_e;

    typedef struct packed {
        dpt_state_e state;
        logic       nonlin;
    } dpt_ctl_s;

endpackage

// File: rtl/pci_dpt_decode.sv
module pci_dpt_decode (
    input  logic in_data_i,
    input  logic frame_n_i,
    input  logic irdy_n_i,
    input  logic trdy_n_i,
    input  logic stop_n_i,
    output logic xfer_o,
    output logic done_o,
    output logic last_o,
    output logic eot_o
);
    logic irdy, trdy, stop, frame;

    always_comb begin
        irdy   = ~irdy_n_i;
        trdy   = ~trdy_n_i;
        stop   = ~stop_n_i;
        frame  = ~frame_n_i;
        xfer_o = in_data_i & irdy & trdy;
        done_o = in_data_i & irdy & (trdy | stop);
        last_o = in_data_i & (~frame | stop);
        eot_o  = in_data_i & irdy & ((~frame & trdy) | stop);
    end
endmodule

// File: rtl/pci_dpt_addr.sv
module pci_dpt_addr #(
    parameter int IDX_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (load_i) begin
            idx_d = load_idx_i;
        end else if (step_i) begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/pci_dphase_tracker.sv
module pci_dphase_tracker
    import pci_dpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              frame_n_i,
    input  logic              irdy_n_i,
    input  logic              trdy_n_i,
    input  logic              stop_n_i,
    output logic              stop_req_o,
    output logic              xfer_o,
    output logic              phase_done_o,
    output logic              last_phase_o,
    output logic              eot_o,
    output logic [ADDR_W-1:0] dword_addr_o
);
    localparam int IDX_W = ADDR_W - 2;

    dpt_ctl_s         ctl_d, ctl_q;
    logic             in_data;
    logic             busy;
    logic             take_claim;
    logic [IDX_W-1:0] idx;

    assign in_data = (ctl_q.state == ST_DATA);
    assign busy    = (ctl_q.state != ST_IDLE);

    pci_dpt_decode u_decode (
        .in_data_i (in_data),
        .frame_n_i (frame_n_i),
        .irdy_n_i  (irdy_n_i),
        .trdy_n_i  (trdy_n_i),
        .stop_n_i  (stop_n_i),
        .xfer_o    (xfer_o),
        .done_o    (phase_done_o),
        .last_o    (last_phase_o),
        .eot_o     (eot_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        take_claim = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (claim_i) begin
                    take_claim   = 1'b1;
                    ctl_d.state  = ST_DATA;
                    ctl_d.nonlin = |start_addr_i[1:0];
                end
            end
            ST_DATA: begin
                if (eot_o) begin
                    if (!frame_n_i) begin
                        ctl_d.state = ST_HOLD;
                    end else begin
                        ctl_d.state  = ST_IDLE;
                        ctl_d.nonlin = 1'b0;
                    end
                end
            end
            ST_HOLD: begin
                if (frame_n_i) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.nonlin = 1'b0;
                end
            end
            default: begin
                ctl_d.state  = ST_IDLE;
                ctl_d.nonlin = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, nonlin: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pci_dpt_addr #(.IDX_W(IDX_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (take_claim),
        .load_idx_i (start_addr_i[ADDR_W-1:2]),
        .step_i     (xfer_o),
        .idx_o      (idx)
    );

    assign stop_req_o   = (in_data & ctl_q.nonlin) | (ctl_q.state == ST_HOLD);
    assign dword_addr_o = {idx, 2'b00};
endmodule

// File: rtl/pci_dphase_tracker_chk.sv
module pci_dphase_tracker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              claim_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              frame_n_i,
    input logic              busy_i,
    input logic              stop_req_o,
    input logic              xfer_o,
    input logic              phase_done_o,
    input logic              last_phase_o,
    input logic              eot_o,
    input logic [ADDR_W-1:0] dword_addr_o
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (!xfer_o && !phase_done_o && !eot_o && !stop_req_o));

    p_xfer_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> phase_done_o);

    p_eot_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eot_o |-> (phase_done_o && last_phase_o));

    p_eot_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_o && frame_n_i) |=> (!busy_i && !stop_req_o));

    p_claim_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && claim_i) |=> (dword_addr_o == ($past(start_addr_i) & ~ADDR_W'(3))));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && xfer_o) |=> (dword_addr_o == $past(dword_addr_o) + ADDR_W'(4)));

    p_addr_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !xfer_o) |=> $stable(dword_addr_o));

    p_linear_nostop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && claim_i && start_addr_i[1:0] == 2'b00) |=> !stop_req_o);

    p_disc_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && claim_i && start_addr_i[1:0] != 2'b00) |=> stop_req_o);

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_o && !frame_n_i) |=> stop_req_o);
endmodule

bind pci_dphase_tracker pci_dphase_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .claim_i      (claim_i),
    .start_addr_i (start_addr_i),
    .frame_n_i    (frame_n_i),
    .busy_i       (busy),
    .stop_req_o   (stop_req_o),
    .xfer_o       (xfer_o),
    .phase_done_o (phase_done_o),
    .last_phase_o (last_phase_o),
    .eot_o        (eot_o),
    .dword_addr_o (dword_addr_o)
);

// File: tb/tb_pci_dphase_tracker.sv
`timescale 1ns/1ps
module tb_pci_dphase_tracker;
    localparam int ADDR_W = 32;
    localparam int NV     = 31;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              claim_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic              frame_n_i = 1'b1;
    logic              irdy_n_i = 1'b1;
    logic              trdy_n_i = 1'b1;
    logic              stop_n_i = 1'b1;
    logic              stop_req_o, xfer_o, phase_done_o, last_phase_o, eot_o;
    logic [ADDR_W-1:0] dword_addr_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pci_dphase_tracker #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .claim_i(claim_i), .start_addr_i(start_addr_i),
        .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .stop_req_o(stop_req_o), .xfer_o(xfer_o), .phase_done_o(phase_done_o),
        .last_phase_o(last_phase_o), .eot_o(eot_o), .dword_addr_o(dword_addr_o)
    );

    // Row: {claim, start_addr, {frame_n,irdy_n,trdy_n,stop_n},
    //       {xfer,done,last,eot,stop_req}, expected dword address}
    localparam logic [73:0] VEC [0:NV-1] = '{
        // R6 linear burst with target and master wait clocks, start 0x1000
        {1'b1, 32'h00001000, 4'b0111, 5'b00000, 32'h00000000},
        {1'b0, 32'h00000000, 4'b0011, 5'b00000, 32'h00001000},
        {1'b0, 32'h00000000, 4'b0001, 5'b11000, 32'h00001000},
        {1'b0, 32'h00000000, 4'b0101, 5'b00000, 32'h00001004},
        {1'b0, 32'h00000000, 4'b0001, 5'b11000, 32'h00001004},
        {1'b0, 32'h00000000, 4'b1101, 5'b00100, 32'h00001008},
        {1'b0, 32'h00000000, 4'b1001, 5'b11110, 32'h00001008},
        {1'b0, 32'h00000000, 4'b1111, 5'b00000, 32'h0000100C},
        // R7 code 01, FRAME# low at transfer, then R8 hold
        {1'b1, 32'h00002001, 4'b0111, 5'b00000, 32'h0000100C},
        {1'b0, 32'h00000000, 4'b0100, 5'b00101, 32'h00002000},
        {1'b0, 32'h00000000, 4'b0000, 5'b11111, 32'h00002000},
        {1'b0, 32'h00000000, 4'b0010, 5'b00001, 32'h00002004},
        {1'b0, 32'h00000000, 4'b1010, 5'b00001, 32'h00002004},
        {1'b0, 32'h00000000, 4'b1111, 5'b00000, 32'h00002004},
        // R7 code 10, FRAME# already high
        {1'b1, 32'h00003002, 4'b0111, 5'b00000, 32'h00002004},
        {1'b0, 32'h00000000, 4'b1000, 5'b11111, 32'h00003000},
        {1'b0, 32'h00000000, 4'b1111, 5'b00000, 32'h00003004},
        // R7 code 11
        {1'b1, 32'h0000400B, 4'b0111, 5'b00000, 32'h00003004},
        {1'b0, 32'h00000000, 4'b0000, 5'b11111, 32'h00004008},
        {1'b0, 32'h00000000, 4'b1110, 5'b00001, 32'h0000400C},
        {1'b0, 32'h00000000, 4'b1111, 5'b00000, 32'h0000400C},
        // R3 single-dword linear transfer
        {1'b1, 32'h00005000, 4'b0111, 5'b00000, 32'h0000400C},
        {1'b0, 32'h00000000, 4'b1001, 5'b11110, 32'h00005000},
        {1'b0, 32'h00000000, 4'b1111, 5'b00000, 32'h00005004},
        // outside STOP# without data; R9 claim mid-burst is ignored
        {1'b1, 32'h00006000, 4'b0111, 5'b00000, 32'h00005004},
        {1'b1, 32'h00007003, 4'b0001, 5'b11000, 32'h00006000},
        {1'b0, 32'h00000000, 4'b0010, 5'b01110, 32'h00006004},
        {1'b1, 32'h00008000, 4'b0110, 5'b00001, 32'h00006004},
        {1'b0, 32'h00000000, 4'b1110, 5'b00001, 32'h00006004},
        {1'b0, 32'h00000000, 4'b1111, 5'b00000, 32'h00006004},
        // R9 handshake while idle gives no strobes
        {1'b0, 32'h00000000, 4'b1000, 5'b00000, 32'h00006004}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " xfer"}, 32'(xfer_o), 32'd0);
        chk({tag, " done"}, 32'(phase_done_o), 32'd0);
        chk({tag, " last"}, 32'(last_phase_o), 32'd0);
        chk({tag, " eot"},  32'(eot_o), 32'd0);
        chk({tag, " stop"}, 32'(stop_req_o), 32'd0);
        chk({tag, " addr"}, dword_addr_o, 32'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk_idle("R10 reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            claim_i      = VEC[i][73];
            start_addr_i = VEC[i][72:41];
            frame_n_i    = VEC[i][40];
            irdy_n_i     = VEC[i][39];
            trdy_n_i     = VEC[i][38];
            stop_n_i     = VEC[i][37];
            #1;
            chk($sformatf("R1 xfer row %0d", i), 32'(xfer_o), 32'(VEC[i][36]));
            chk($sformatf("R2 done row %0d", i), 32'(phase_done_o), 32'(VEC[i][35]));
            chk($sformatf("R4 last row %0d", i), 32'(last_phase_o), 32'(VEC[i][34]));
            chk($sformatf("R3 eot row %0d", i), 32'(eot_o), 32'(VEC[i][33]));
            chk($sformatf("R7/R8 stop row %0d", i), 32'(stop_req_o), 32'(VEC[i][32]));
            chk($sformatf("R5/R6 addr row %0d", i), dword_addr_o, VEC[i][31:0]);
        end

        // R10: reset in the middle of a disconnect
        @(negedge clk);
        claim_i = 1'b1; start_addr_i = 32'h00009001;
        frame_n_i = 1'b0; irdy_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1;
        @(negedge clk);
        claim_i = 1'b0; start_addr_i = '0;
        #1;
        chk("R7 stop before mid reset", 32'(stop_req_o), 32'd1);
        chk("R5 addr before mid reset", dword_addr_o, 32'h00009000);
        irdy_n_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk_idle("R10 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        frame_n_i = 1'b1; irdy_n_i = 1'b1;
        @(negedge clk);
        #1;
        chk_idle("R10 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule